// File: doc/BRIEF.md
# Three-Thread Interleaved Integer Pipeline

This block is a small integer execution pipeline that three independent hardware threads share in a fixed rotation. Each clock cycle belongs to exactly one thread. The thread whose turn it is may present one register-to-register operation, or a bubble. An internal slot counter advances 0, 1, 2, 0 and travels with every operation as a tag. Each pipeline register therefore holds work from a different thread, and the single core behaves like three processors, each running at a third of the clock rate.

Every thread has its own bank of architectural registers. Operands are read from the bank of the thread that issued the operation, and results are written to that same bank. One operation of a thread takes three register stages from issue to write-back: issue, operand read, and execute. A thread gets its next slot only after its previous result has reached the register file, so dependent operations need no forwarding path and no interlock.

Results leave the block as a tagged write-back stream. A debug port reads any register of any thread at any time.

Top module: `cslow_core`

## Requirements
- R1: `slot_tid` follows the sequence 0, 1, 2, 0, ... and advances by one every clock cycle. It is 0 while reset is active.
- R2: An operation presented in a cycle with `slot_tid` = T appears on the write-back port three rising clock edges later. At that point `wb_valid` = 1, `wb_tid` = T and `wb_rd` equals the destination index that was presented.
- R3: Opcode encoding and results, all wrapping modulo 2^32:
  - 1 = add, rs1+rs2
  - 2 = sub, rs1-rs2
  - 3 = and, rs1&rs2
  - 4 = or, rs1|rs2
  - 5 = xor, rs1^rs2
  - 6 = add-immediate, rs1 plus the 16-bit immediate sign-extended
- R4: Opcode 0 (bubble) and the unused opcode 7 produce no write-back (`wb_valid` = 0) and change no register.
- R5: A write-back changes only the register bank of the thread given by its tag. Registers of the other threads keep their values.
- R6: Register index 0 of every bank always reads as zero. An operation that targets index 0 still reports its result on the write-back port, but it leaves the register reading zero.
- R7: An operation that reads a register written by the same thread's previous operation in the immediately preceding slot gets the new value, with no forwarding logic.
- R8: `dbg_data` shows, in the same cycle, the content of register `dbg_idx` in the bank selected by `dbg_tid`.
- R9: Reset is asserted asynchronously and clears all registers of all banks and all pipeline valid bits, so `wb_valid` = 0. Reset is released on the clock through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_tid | output | 2 | Thread that owns the current issue slot |
| in_opcode | input | 3 | Operation code for the current slot |
| in_rd | input | 3 | Destination register index |
| in_rs1 | input | 3 | First source register index |
| in_rs2 | input | 3 | Second source register index |
| in_imm | input | 16 | Immediate for add-immediate |
| wb_valid | output | 1 | Write-back result present |
| wb_tid | output | 2 | Thread tag of the write-back |
| wb_rd | output | 3 | Destination index of the write-back |
| wb_data | output | 32 | Write-back result |
| dbg_tid | input | 2 | Debug read thread select |
| dbg_idx | input | 3 | Debug read register index |
| dbg_data | output | 32 | Debug read data |

## Verification
The bench builds the block with its default parameters: three threads, eight 32-bit registers per thread and a 16-bit immediate. With only eight register indices, random operations often read a register that the same thread wrote one slot earlier, so dependent chains without forwarding occur all the time. Random immediates with the top bit set exercise sign extension, and random 32-bit operands make add and sub wrap around. Three banks of eight registers are few enough that the bench compares all of them through the debug port, including every register 0, after random traffic and again after a reset asserted mid-run.

// File: rtl/cslow_pkg.sv
package cslow_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_AND  = 3'd3,
    OP_OR   = 3'd4,
    OP_XOR  = 3'd5,
    OP_ADDI = 3'd6,
    OP_RSVD = 3'd7
  } opcode_e;

  // True for the opcodes that produce a write-back
  function automatic logic op_writes(input logic [2:0] code);
    return (code != 3'd0) && (code != 3'd7);
  endfunction

endpackage

// File: rtl/cslow_rst_sync.sv
module cslow_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/cslow_tid_ring.sv
module cslow_tid_ring #(
  parameter int NTHREADS = 3,
  parameter int TIDW     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TIDW-1:0] tid
);
  logic [TIDW-1:0] tid_next;

  always_comb begin
    if (tid == TIDW'(NTHREADS - 1)) tid_next = '0;
    else                            tid_next = tid + TIDW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tid <= '0;
    else        tid <= tid_next;
  end
endmodule

// File: rtl/cslow_bank.sv
module cslow_bank #(
  parameter int NREGS = 8,
  parameter int XLEN  = 32,
  parameter int RIDXW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [RIDXW-1:0] widx,
  input  logic [XLEN-1:0]  wdata,
  input  logic [RIDXW-1:0] ra_idx,
  input  logic [RIDXW-1:0] rb_idx,
  input  logic [RIDXW-1:0] rd_idx,
  output logic [XLEN-1:0]  ra_data,
  output logic [XLEN-1:0]  rb_data,
  output logic [XLEN-1:0]  rd_data
);
  logic [XLEN-1:0] mem [NREGS];
  logic            wr_en;

  // index 0 is never stored
  always_comb wr_en = we && (widx != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[widx] <= wdata;
    end
  end

  always_comb begin
    ra_data = (ra_idx == '0) ? '0 : mem[ra_idx];
    rb_data = (rb_idx == '0) ? '0 : mem[rb_idx];
    rd_data = (rd_idx == '0) ? '0 : mem[rd_idx];
  end
endmodule

// File: rtl/cslow_regbank.sv
module cslow_regbank #(
  parameter int NTHREADS = 3,
  parameter int NREGS    = 8,
  parameter int XLEN     = 32,
  parameter int TIDW     = 2,
  parameter int RIDXW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [TIDW-1:0]  wtid,
  input  logic [RIDXW-1:0] widx,
  input  logic [XLEN-1:0]  wdata,
  input  logic [TIDW-1:0]  rtid,
  input  logic [RIDXW-1:0] ra_idx,
  input  logic [RIDXW-1:0] rb_idx,
  output logic [XLEN-1:0]  ra_data,
  output logic [XLEN-1:0]  rb_data,
  input  logic [TIDW-1:0]  dtid,
  input  logic [RIDXW-1:0] didx,
  output logic [XLEN-1:0]  ddata
);
  logic [NTHREADS-1:0][XLEN-1:0] ra_all, rb_all, dd_all;

  for (genvar g = 0; g < NTHREADS; g++) begin : g_bank
    logic bank_we;
    always_comb bank_we = we && (wtid == TIDW'(g));

    cslow_bank #(.NREGS(NREGS), .XLEN(XLEN), .RIDXW(RIDXW)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (bank_we),
      .widx    (widx),
      .wdata   (wdata),
      .ra_idx  (ra_idx),
      .rb_idx  (rb_idx),
      .rd_idx  (didx),
      .ra_data (ra_all[g]),
      .rb_data (rb_all[g]),
      .rd_data (dd_all[g])
    );
  end

  always_comb begin
    ra_data = '0;
    rb_data = '0;
    ddata   = '0;
    for (int t = 0; t < NTHREADS; t++) begin
      if (rtid == TIDW'(t)) begin
        ra_data = ra_all[t];
        rb_data = rb_all[t];
      end
      if (dtid == TIDW'(t)) ddata = dd_all[t];
    end
  end
endmodule

// File: rtl/cslow_alu.sv
module cslow_alu
  import cslow_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  opcode_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  always_comb begin
    unique case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/cslow_core.sv
module cslow_core
  import cslow_pkg::*;
#(
  parameter int NTHREADS = 3,
  parameter int NREGS    = 8,
  parameter int XLEN     = 32,
  parameter int IMMW     = 16,
  localparam int TIDW    = (NTHREADS > 1) ? $clog2(NTHREADS) : 1,
  localparam int RIDXW   = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [TIDW-1:0]  slot_tid,
  input  logic [2:0]       in_opcode,
  input  logic [RIDXW-1:0] in_rd,
  input  logic [RIDXW-1:0] in_rs1,
  input  logic [RIDXW-1:0] in_rs2,
  input  logic [IMMW-1:0]  in_imm,
  output logic             wb_valid,
  output logic [TIDW-1:0]  wb_tid,
  output logic [RIDXW-1:0] wb_rd,
  output logic [XLEN-1:0]  wb_data,
  input  logic [TIDW-1:0]  dbg_tid,
  input  logic [RIDXW-1:0] dbg_idx,
  output logic [XLEN-1:0]  dbg_data
);
  logic rst_sync_n;

  cslow_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  cslow_tid_ring #(.NTHREADS(NTHREADS), .TIDW(TIDW)) u_ring (
    .clk(clk), .rst_n(rst_sync_n), .tid(slot_tid)
  );

  // Stage 1: issue register
  logic             s1_en;
  logic             s1_valid;
  opcode_e          s1_op;
  logic [TIDW-1:0]  s1_tid;
  logic [RIDXW-1:0] s1_rd, s1_rs1, s1_rs2;
  logic [IMMW-1:0]  s1_imm;

  always_comb s1_en = op_writes(in_opcode);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_valid <= 1'b0;
      s1_op    <= OP_NOP;
      s1_tid   <= '0;
      s1_rd    <= '0;
      s1_rs1   <= '0;
      s1_rs2   <= '0;
      s1_imm   <= '0;
    end else begin
      s1_valid <= s1_en;
      if (s1_en) begin
        s1_op  <= opcode_e'(in_opcode);
        s1_tid <= slot_tid;
        s1_rd  <= in_rd;
        s1_rs1 <= in_rs1;
        s1_rs2 <= in_rs2;
        s1_imm <= in_imm;
      end
    end
  end

  // Register file read, addressed by stage 1 tag
  logic [XLEN-1:0] rf_a, rf_b;

  // Stage 2: operand register
  logic             s2_valid;
  opcode_e          s2_op, s2_op_n;
  logic [TIDW-1:0]  s2_tid;
  logic [RIDXW-1:0] s2_rd;
  logic [XLEN-1:0]  s2_a, s2_b, s2_b_n;

  always_comb begin
    if (s1_op == OP_ADDI) begin
      s2_op_n = OP_ADD;
      s2_b_n  = {{(XLEN-IMMW){s1_imm[IMMW-1]}}, s1_imm};
    end else begin
      s2_op_n = s1_op;
      s2_b_n  = rf_b;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s2_valid <= 1'b0;
      s2_op    <= OP_NOP;
      s2_tid   <= '0;
      s2_rd    <= '0;
      s2_a     <= '0;
      s2_b     <= '0;
    end else begin
      s2_valid <= s1_valid;
      if (s1_valid) begin
        s2_op  <= s2_op_n;
        s2_tid <= s1_tid;
        s2_rd  <= s1_rd;
        s2_a   <= rf_a;
        s2_b   <= s2_b_n;
      end
    end
  end

  // Stage 3: execute, result register drives write-back
  logic [XLEN-1:0] alu_y;

  cslow_alu #(.XLEN(XLEN)) u_alu (.op(s2_op), .a(s2_a), .b(s2_b), .y(alu_y));

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wb_valid <= 1'b0;
      wb_tid   <= '0;
      wb_rd    <= '0;
      wb_data  <= '0;
    end else begin
      wb_valid <= s2_valid;
      if (s2_valid) begin
        wb_tid  <= s2_tid;
        wb_rd   <= s2_rd;
        wb_data <= alu_y;
      end
    end
  end

  cslow_regbank #(
    .NTHREADS(NTHREADS), .NREGS(NREGS), .XLEN(XLEN), .TIDW(TIDW), .RIDXW(RIDXW)
  ) u_rf (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we      (wb_valid),
    .wtid    (wb_tid),
    .widx    (wb_rd),
    .wdata   (wb_data),
    .rtid    (s1_tid),
    .ra_idx  (s1_rs1),
    .rb_idx  (s1_rs2),
    .ra_data (rf_a),
    .rb_data (rf_b),
    .dtid    (dbg_tid),
    .didx    (dbg_idx),
    .ddata   (dbg_data)
  );
endmodule

// File: rtl/cslow_core_checker.sv
module cslow_core_checker #(
  parameter int NTHREADS = 3,
  parameter int XLEN     = 32,
  parameter int TIDW     = 2,
  parameter int RIDXW    = 3
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic [TIDW-1:0]  slot_tid,
  input logic [2:0]       in_opcode,
  input logic             wb_valid,
  input logic [TIDW-1:0]  wb_tid,
  input logic [TIDW-1:0]  dbg_tid,
  input logic [RIDXW-1:0] dbg_idx,
  input logic [XLEN-1:0]  dbg_data
);
  // R1: slot owner stays in range
  a_r1_tid_range: assert property (@(posedge clk) disable iff (!rst_sync_n)
    int'(slot_tid) < NTHREADS);

  // R1: last thread wraps to thread 0
  a_r1_tid_wrap: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (slot_tid == TIDW'(NTHREADS - 1)) |=> (slot_tid == '0));

  // R1: other threads advance by one
  a_r1_tid_step: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (slot_tid != TIDW'(NTHREADS - 1)) |=> (slot_tid == $past(slot_tid) + TIDW'(1)));

  // R2: write-back tag is the slot owner three edges earlier
  a_r2_wb_tag: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wb_valid |-> (wb_tid == $past(slot_tid, 3)));

  // R4: write-back only for a real operation issued three edges earlier
  a_r4_no_bubble_wb: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wb_valid |-> ($past(in_opcode, 3) != 3'd0 && $past(in_opcode, 3) != 3'd7));

  // R4, R8: without a write-back, a held debug address sees held data
  a_r8_dbg_stable: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wb_valid |=> (!$stable(dbg_tid) || !$stable(dbg_idx) || $stable(dbg_data)));

  // R6: index 0 reads zero in every bank
  a_r6_zero_reg: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dbg_idx == '0) |-> (dbg_data == '0));
endmodule

bind cslow_core cslow_core_checker #(
  .NTHREADS(NTHREADS), .XLEN(XLEN), .TIDW(TIDW), .RIDXW(RIDXW)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .slot_tid   (slot_tid),
  .in_opcode  (in_opcode),
  .wb_valid   (wb_valid),
  .wb_tid     (wb_tid),
  .dbg_tid    (dbg_tid),
  .dbg_idx    (dbg_idx),
  .dbg_data   (dbg_data)
);

// File: tb/cslow_core_test.sv
`timescale 1ns/1ps
module cslow_core_test;
  localparam int NT = 3;
  localparam int NR = 8;

  logic        clk;
  logic        rst_n;
  logic [1:0]  slot_tid;
  logic [2:0]  in_opcode;
  logic [2:0]  in_rd, in_rs1, in_rs2;
  logic [15:0] in_imm;
  logic        wb_valid;
  logic [1:0]  wb_tid;
  logic [2:0]  wb_rd;
  logic [31:0] wb_data;
  logic [1:0]  dbg_tid;
  logic [2:0]  dbg_idx;
  logic [31:0] dbg_data;

  cslow_core uut (
    .clk(clk), .rst_n(rst_n), .slot_tid(slot_tid),
    .in_opcode(in_opcode), .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2),
    .in_imm(in_imm), .wb_valid(wb_valid), .wb_tid(wb_tid), .wb_rd(wb_rd),
    .wb_data(wb_data), .dbg_tid(dbg_tid), .dbg_idx(dbg_idx), .dbg_data(dbg_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] model [NT][NR];

  // expected write-back pipe, index 2 is oldest
  logic        p_v   [3];
  logic [1:0]  p_tid [3];
  logic [2:0]  p_rd  [3];
  logic [31:0] p_dat [3];

  int  last_slot;
  bit  slot_known;

  function automatic logic [31:0] calc(input int op, input logic [31:0] a,
                                       input logic [31:0] b, input logic [15:0] imm);
    case (op)
      1: return a + b;
      2: return a - b;
      3: return a & b;
      4: return a | b;
      5: return a ^ b;
      6: return a + {{16{imm[15]}}, imm};
      default: return 32'h0;
    endcase
  endfunction

  task automatic note(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int next_slot();
    return (last_slot + 1) % NT;
  endfunction

  // One issue cycle: check outputs, then drive the op for the current slot
  task automatic step(input int op, input int rd, input int rs1, input int rs2,
                      input logic [15:0] imm);
    int          t;
    bit          wr;
    logic [31:0] res;
    @(negedge clk);
    // R2 R3 R4 R7: write-back of the op issued three cycles ago
    if (p_v[2])
      note(wb_valid && wb_tid == p_tid[2] && wb_rd == p_rd[2] && wb_data == p_dat[2],
           "R2 R3 R7 write-back",
           {27'd0, wb_valid, wb_tid, wb_rd, wb_data},
           {27'd0, 1'b1, p_tid[2], p_rd[2], p_dat[2]});
    else
      note(!wb_valid, "R4 bubble gives no write-back", {63'd0, wb_valid}, 64'd0);
    // R1: rotation
    if (slot_known)
      note(int'(slot_tid) == next_slot(), "R1 slot rotation", 64'(slot_tid),
           64'(next_slot()));
    last_slot  = int'(slot_tid);
    slot_known = 1'b1;
    t   = int'(slot_tid);
    wr  = (op >= 1 && op <= 6);
    res = calc(op, model[t][rs1], model[t][rs2], imm);
    if (wr && rd != 0) model[t][rd] = res;
    p_v[2] = p_v[1];   p_tid[2] = p_tid[1]; p_rd[2] = p_rd[1]; p_dat[2] = p_dat[1];
    p_v[1] = p_v[0];   p_tid[1] = p_tid[0]; p_rd[1] = p_rd[0]; p_dat[1] = p_dat[0];
    p_v[0] = wr;       p_tid[0] = 2'(t);    p_rd[0] = 3'(rd);  p_dat[0] = res;
    in_opcode = 3'(op);
    in_rd     = 3'(rd);
    in_rs1    = 3'(rs1);
    in_rs2    = 3'(rs2);
    in_imm    = imm;
  endtask

  task automatic read_dbg(input int t, input int i, input logic [31:0] exp,
                          input string req);
    @(negedge clk);
    dbg_tid = 2'(t);
    dbg_idx = 3'(i);
    #1;
    note(dbg_data == exp, req, 64'(dbg_data), 64'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    rst_n = 1'b0;
    in_opcode = '0; in_rd = '0; in_rs1 = '0; in_rs2 = '0; in_imm = '0;
    dbg_tid = '0; dbg_idx = '0;
    slot_known = 1'b0;
    last_slot  = 0;
    for (int k = 0; k < 3; k++) begin
      p_v[k] = 1'b0; p_tid[k] = '0; p_rd[k] = '0; p_dat[k] = '0;
    end
    for (int t = 0; t < NT; t++)
      for (int i = 0; i < NR; i++) model[t][i] = 32'h0;

    repeat (4) @(negedge clk);
    #1;
    // R9 R1: reset state
    note(!wb_valid, "R9 reset wb_valid", {63'd0, wb_valid}, 64'd0);
    note(slot_tid == 2'd0, "R1 reset slot", 64'(slot_tid), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Directed: per-thread seeds then dependent chains (R7)
    for (int k = 0; k < NT; k++) step(6, 1, 0, 0, 16'(next_slot() * 100 + 7));
    for (int r = 0; r < 4; r++)
      for (int k = 0; k < NT; k++) step(6, 1, 1, 0, 16'd1);
    for (int k = 0; k < NT; k++) step(1, 2, 1, 1, 16'd0);
    // R3: sign-extended negative immediate, wrap in sub
    for (int k = 0; k < NT; k++) step(6, 3, 0, 0, 16'hFFFF);
    for (int k = 0; k < NT; k++) step(2, 4, 0, 1, 16'd0);
    for (int k = 0; k < NT; k++) step(1, 5, 3, 3, 16'd0);
    // R6: target index 0
    for (int k = 0; k < NT; k++) step(1, 0, 1, 2, 16'd0);
    for (int k = 0; k < NT; k++) step(6, 6, 0, 0, 16'h0042);
    // R4: reserved opcode and bubble
    for (int k = 0; k < NT; k++) step(7, 1, 2, 2, 16'h1234);
    for (int k = 0; k < NT; k++) step(0, 1, 2, 2, 16'h1234);
    // R4 R5: only thread 1 writes, others bubble
    for (int k = 0; k < NT; k++) begin
      if (next_slot() == 1) step(5, 7, 1, 4, 16'd0);
      else                  step(0, 7, 1, 4, 16'd0);
    end
    for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 16'd0);
    for (int t = 0; t < NT; t++) begin
      read_dbg(t, 0, 32'h0, "R6 index 0 reads zero");
      read_dbg(t, 7, model[t][7], "R5 bank isolation");
      read_dbg(t, 1, model[t][1], "R4 R7 chain result kept");
    end

    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op > 7) op = 6;
      step(op, int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
           int'($urandom_range(0, 7)), 16'($urandom));
    end
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 16'd0);

    // R8 R5 R6: full bank comparison
    for (int t = 0; t < NT; t++)
      for (int i = 0; i < NR; i++) read_dbg(t, i, model[t][i], "R8 R5 debug read");

    // R9: reset mid-run clears every bank
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    note(!wb_valid, "R9 mid-run reset wb_valid", {63'd0, wb_valid}, 64'd0);
    note(slot_tid == 2'd0, "R9 mid-run reset slot", 64'(slot_tid), 64'd0);
    for (int t = 0; t < NT; t++)
      for (int i = 0; i < NR; i++) read_dbg(t, i, 32'h0, "R9 banks cleared");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule